// File: doc/BRIEF.md
# Accumulator ALU with Operand Steering

This block is the 8-bit arithmetic unit of a small accumulator-style processor core. Two 4-way selects choose operand A and operand B. The sources are the working register, the value read from the file register, the immediate byte of the instruction, and one of two special values. For A the special value is a one-hot bit mask. For B it is the constant one. The mask is built from the 3-bit bit-index field of the immediate byte, and a polarity input can invert it.

A 4-bit code then picks one of nine operations. These let one narrow unit cover several instruction kinds without dedicated hardware:

- increment and decrement, as add or subtract with B set to one;
- moves, as OR of a source with itself;
- clears, as XOR of a source with itself;
- single-bit set, clear and test, through the mask with OR, inverted-mask AND, and plain-mask AND followed by the zero flag.

The result, the zero flag and the carry flag are registered once before they leave the block. A synchronous active-high reset clears the output register.

Top module: `acc_alu`

## Requirements
- R1: Operand A select `a_sel_i` picks 00 = working register, 01 = file register, 10 = immediate byte, 11 = bit mask.
- R2: Operand B select `b_sel_i` picks 00 = working register, 01 = file register, 10 = immediate byte, 11 = the constant 1.
- R3: The bit mask has exactly one bit set, at position `imm_i[7:5]`, when `mask_inv_i` is low. It is the bitwise inverse of that mask when `mask_inv_i` is high.
- R4: Op 0000 gives A + B. The carry output is the carry out of bit 7.
- R5: Op 1000 gives A - B, computed as A + ~B + 1. The carry output is 1 when no borrow occurred.
- R6: Ops 0001, 0010 and 0011 give A AND B, A OR B and A XOR B. These three pass `carry_i` through to the carry output.
- R7: Op 0100 gives ~A and op 0111 swaps the two nibbles of A. Both pass `carry_i` through to the carry output.
- R8: Op 0101 rotates A right through carry. `carry_i` enters bit 7, and bit 0 of A becomes the carry output.
- R9: Op 0110 rotates A left through carry. `carry_i` enters bit 0, and bit 7 of A becomes the carry output.
- R10: Op codes 1001 through 1111 give result 0 and pass `carry_i` through to the carry output.
- R11: `zero_o` is high exactly when `result_o` is all zeros.
- R12: Outputs take the value for the inputs present at a rising clock edge, and hold it until the next edge. A reset edge sets result 0, carry 0 and zero 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wreg_i | input | 8 | Working register value |
| freg_i | input | 8 | File register read value |
| imm_i | input | 8 | Immediate byte of the instruction; bits [7:5] are the bit index |
| a_sel_i | input | 2 | Operand A source select |
| b_sel_i | input | 2 | Operand B source select |
| op_i | input | 4 | Operation code |
| mask_inv_i | input | 1 | Invert the bit mask when high |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 8 | Registered result |
| zero_o | output | 1 | Registered zero flag |
| carry_o | output | 1 | Registered carry result |

## Verification
All three outputs pass through a single register stage. Each result is therefore due at the first rising edge after the inputs are applied, and the reset values are due at the first edge with reset high. The bench drives every stimulus on a falling edge and lets one rising edge pass. It samples on the following falling edge, so each comparison sees exactly the value captured from that stimulus. Directed cases cover every select code, all mask positions in both polarities, the carry and borrow edges, and every unused code. A sweep of pseudo-random vectors is then checked against a bench-side model written from the requirements.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [1:0] {
    A_WREG = 2'b00,
    A_FREG = 2'b01,
    A_IMM  = 2'b10,
    A_MASK = 2'b11
  } a_src_e;

  typedef enum logic [1:0] {
    B_WREG = 2'b00,
    B_FREG = 2'b01,
    B_IMM  = 2'b10,
    B_ONE  = 2'b11
  } b_src_e;

  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000,
    OP_AND  = 4'b0001,
    OP_OR   = 4'b0010,
    OP_XOR  = 4'b0011,
    OP_CPL  = 4'b0100,
    OP_RRC  = 4'b0101,
    OP_RLC  = 4'b0110,
    OP_SWAP = 4'b0111,
    OP_SUB  = 4'b1000
  } alu_op_e;

endpackage

// File: rtl/operand_steer.sv
module operand_steer
  import acc_alu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int IDX_LSB = 5
) (
  input  logic [DATA_W-1:0] wreg,
  input  logic [DATA_W-1:0] freg,
  input  logic [DATA_W-1:0] imm,
  input  logic [1:0]        a_sel,
  input  logic [1:0]        b_sel,
  input  logic              mask_inv,
  output logic [DATA_W-1:0] a_opnd,
  output logic [DATA_W-1:0] b_opnd
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] mask_hot;
  logic [DATA_W-1:0] mask_eff;

  assign bit_idx = imm[IDX_LSB +: IDX_W];

  // one comparator per mask bit
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask_hot[g] = (bit_idx == IDX_W'(g));
  end

  assign mask_eff = mask_hot ^ {DATA_W{mask_inv}};

  always_comb begin
    unique case (a_src_e'(a_sel))
      A_WREG:  a_opnd = wreg;
      A_FREG:  a_opnd = freg;
      A_IMM:   a_opnd = imm;
      default: a_opnd = mask_eff;
    endcase
  end

  always_comb begin
    unique case (b_src_e'(b_sel))
      B_WREG:  b_opnd = wreg;
      B_FREG:  b_opnd = freg;
      B_IMM:   b_opnd = imm;
      default: b_opnd = DATA_W'(1);
    endcase
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [3:0]        op,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  localparam int HALF = DATA_W / 2;

  logic              is_sub;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum_ext;

  // one shared adder for add and subtract
  assign is_sub  = (op == OP_SUB);
  assign b_eff   = is_sub ? ~b : b;
  assign sum_ext = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, is_sub};

  always_comb begin
    res  = '0;
    cout = cin;
    case (alu_op_e'(op))
      OP_ADD, OP_SUB: begin
        res  = sum_ext[DATA_W-1:0];
        cout = sum_ext[DATA_W];
      end
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CPL:  res = ~a;
      OP_RRC: begin
        res  = {cin, a[DATA_W-1:1]};
        cout = a[0];
      end
      OP_RLC: begin
        res  = {a[DATA_W-2:0], cin};
        cout = a[DATA_W-1];
      end
      OP_SWAP: res = {a[HALF-1:0], a[DATA_W-1:HALF]};
      default: begin
        res  = '0;
        cout = cin;
      end
    endcase
  end

endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int          W        = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int IDX_LSB = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        wreg_i,
  input  logic [7:0]        freg_i,
  input  logic [7:0]        imm_i,
  input  logic [1:0]        a_sel_i,
  input  logic [1:0]        b_sel_i,
  input  logic [3:0]        op_i,
  input  logic              mask_inv_i,
  input  logic              carry_i,
  output logic [7:0]        result_o,
  output logic              zero_o,
  output logic              carry_o
);

  localparam int OUT_W = DATA_W + 2;
  localparam logic [OUT_W-1:0] OUT_RST = {{DATA_W{1'b0}}, 1'b1, 1'b0};

  logic [DATA_W-1:0] a_opnd;
  logic [DATA_W-1:0] b_opnd;
  logic [DATA_W-1:0] alu_res;
  logic              alu_c;
  logic [OUT_W-1:0]  out_d;
  logic [OUT_W-1:0]  out_q;

  operand_steer #(
    .DATA_W  (DATA_W),
    .IDX_LSB (IDX_LSB)
  ) i_steer (
    .wreg     (wreg_i),
    .freg     (freg_i),
    .imm      (imm_i),
    .a_sel    (a_sel_i),
    .b_sel    (b_sel_i),
    .mask_inv (mask_inv_i),
    .a_opnd   (a_opnd),
    .b_opnd   (b_opnd)
  );

  alu_core #(
    .DATA_W (DATA_W)
  ) i_core (
    .a    (a_opnd),
    .b    (b_opnd),
    .op   (op_i),
    .cin  (carry_i),
    .res  (alu_res),
    .cout (alu_c)
  );

  assign out_d = {alu_res, ~|alu_res, alu_c};

  out_stage #(
    .W       (OUT_W),
    .RST_VAL (OUT_RST)
  ) i_out (
    .clk (clk),
    .rst (rst),
    .d   (out_d),
    .q   (out_q)
  );

  assign result_o = out_q[OUT_W-1:2];
  assign zero_o   = out_q[1];
  assign carry_o  = out_q[0];

  // R3: mask is one-hot, or one-cold when inverted
  p_mask_hot_r3: assert property (@(posedge clk) disable iff (rst)
    (a_sel_i == A_MASK && !mask_inv_i) |-> $countones(a_opnd) == 1);
  p_mask_cold_r3: assert property (@(posedge clk) disable iff (rst)
    (a_sel_i == A_MASK && mask_inv_i) |-> $countones(a_opnd) == DATA_W - 1);

  // R4: adding zero returns A with no carry
  p_add_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ADD && b_opnd == '0) |=>
      (result_o == $past(a_opnd) && !carry_o));

  // R5: equal operands subtract to zero with no borrow
  p_sub_equal_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SUB && a_opnd == b_opnd) |=> (zero_o && carry_o));

  // R7: complement and swap leave carry alone
  p_keep_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CPL || op_i == OP_SWAP) |=> carry_o == $past(carry_i));

  // R8: rotate right moves bit 0 out and carry into the top bit
  p_rot_right_r8: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_RRC) |=>
      (carry_o == $past(a_opnd[0]) && result_o[DATA_W-1] == $past(carry_i)));

  // R10: unused codes give zero with carry passed through
  p_unused_op_r10: assert property (@(posedge clk) disable iff (rst)
    (op_i > OP_SUB) |=> (result_o == '0 && carry_o == $past(carry_i)));

  // R11: zero flag agrees with the registered result
  p_zero_flag_r11: assert property (@(posedge clk) disable iff (rst)
    zero_o == (result_o == '0));

  // R12: reset loads the fixed output values
  p_reset_val_r12: assert property (@(posedge clk)
    rst |=> (result_o == '0 && zero_o && !carry_o));

endmodule

// File: tb/test_acc_alu.sv
module test_acc_alu;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst;
  logic [7:0] wreg_i, freg_i, imm_i;
  logic [1:0] a_sel_i, b_sel_i;
  logic [3:0] op_i;
  logic       mask_inv_i, carry_i;
  logic [7:0] result_o;
  logic       zero_o, carry_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  acc_alu i_acc_alu (
    .clk(clk), .rst(rst), .wreg_i(wreg_i), .freg_i(freg_i), .imm_i(imm_i),
    .a_sel_i(a_sel_i), .b_sel_i(b_sel_i), .op_i(op_i), .mask_inv_i(mask_inv_i),
    .carry_i(carry_i), .result_o(result_o), .zero_o(zero_o), .carry_o(carry_o)
  );

  initial begin
    clk = 0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input string req, input logic [7:0] er,
                     input logic ez, input logic ec);
    n_checks++;
    if (result_o !== er || zero_o !== ez || carry_o !== ec) begin
      n_fails++;
      $display("FAIL %s: got res=%02h z=%b c=%b, expected res=%02h z=%b c=%b",
               req, result_o, zero_o, carry_o, er, ez, ec);
    end
  endtask

  // drive on a falling edge, capture at the rising edge, sample on the next fall
  task automatic apply(input logic [7:0] w, input logic [7:0] f,
                       input logic [7:0] imm, input logic [1:0] as,
                       input logic [1:0] bs, input logic [3:0] op,
                       input logic inv, input logic cin);
    wreg_i = w; freg_i = f; imm_i = imm; a_sel_i = as; b_sel_i = bs;
    op_i = op; mask_inv_i = inv; carry_i = cin;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input string req, input logic [7:0] w, input logic [7:0] f,
                     input logic [7:0] imm, input logic [1:0] as,
                     input logic [1:0] bs, input logic [3:0] op,
                     input logic inv, input logic cin, input logic [7:0] er,
                     input logic ec);
    apply(w, f, imm, as, bs, op, inv, cin);
    chk(req, er, er == 8'h00, ec);
  endtask

  // bench model written from the requirement list
  function automatic logic [9:0] model(input logic [7:0] w, input logic [7:0] f,
      input logic [7:0] imm, input logic [1:0] as, input logic [1:0] bs,
      input logic [3:0] op, input logic inv, input logic cin);
    logic [7:0] a, b, m, r;
    logic [8:0] s;
    logic c;
    m = 8'h01 << imm[7:5];
    if (inv) m = ~m;
    a = (as == 2'd0) ? w : (as == 2'd1) ? f : (as == 2'd2) ? imm : m;
    b = (bs == 2'd0) ? w : (bs == 2'd1) ? f : (bs == 2'd2) ? imm : 8'h01;
    c = cin; r = 8'h00;
    case (op)
      4'd0: begin s = a + b; r = s[7:0]; c = s[8]; end
      4'd8: begin r = a - b; c = (a >= b); end
      4'd1: r = a & b;
      4'd2: r = a | b;
      4'd3: r = a ^ b;
      4'd4: r = ~a;
      4'd5: begin r = {cin, a[7:1]}; c = a[0]; end
      4'd6: begin r = {a[6:0], cin}; c = a[7]; end
      4'd7: r = {a[3:0], a[7:4]};
      default: begin r = 8'h00; c = cin; end
    endcase
    return {r, r == 8'h00, c};
  endfunction

  task automatic t_reset;
    rst = 1;
    apply(8'hFF, 8'hFF, 8'hFF, 2'd0, 2'd0, 4'd0, 1'b0, 1'b1);
    chk("R12 reset", 8'h00, 1'b1, 1'b0);
    rst = 0;
  endtask

  task automatic t_sel_a;  // R1 via complement of A
    run("R1 a=wreg", 8'h3C, 8'hA5, 8'h5A, 2'd0, 2'd1, 4'd4, 1'b0, 1'b0, 8'hC3, 1'b0);
    run("R1 a=freg", 8'h3C, 8'hA5, 8'h5A, 2'd1, 2'd0, 4'd4, 1'b0, 1'b1, 8'h5A, 1'b1);
    run("R1 a=imm",  8'h3C, 8'hA5, 8'h5A, 2'd2, 2'd0, 4'd4, 1'b0, 1'b0, 8'hA5, 1'b0);
    run("R1 a=mask", 8'h3C, 8'hA5, 8'h5A, 2'd3, 2'd0, 4'd4, 1'b0, 1'b0, 8'hFB, 1'b0);
  endtask

  task automatic t_sel_b;  // R2 via OR with A = file 00
    run("R2 b=wreg", 8'h3C, 8'h00, 8'h5A, 2'd1, 2'd0, 4'd2, 1'b0, 1'b0, 8'h3C, 1'b0);
    run("R2 b=freg", 8'h3C, 8'h00, 8'h5A, 2'd1, 2'd1, 4'd2, 1'b0, 1'b0, 8'h00, 1'b0);
    run("R2 b=imm",  8'h3C, 8'h00, 8'h5A, 2'd1, 2'd2, 4'd2, 1'b0, 1'b0, 8'h5A, 1'b0);
    run("R2 b=one",  8'h3C, 8'h00, 8'h5A, 2'd1, 2'd3, 4'd2, 1'b0, 1'b0, 8'h01, 1'b0);
  endtask

  task automatic t_mask;  // R3 every index, both polarities, set and clear
    for (int i = 0; i < 8; i++) begin
      run("R3 set bit", 8'h00, 8'h00, 8'(i << 5), 2'd3, 2'd1, 4'd2, 1'b0, 1'b0,
          8'(1 << i), 1'b0);
      run("R3 clear bit", 8'h00, 8'hFF, 8'(i << 5), 2'd3, 2'd1, 4'd1, 1'b1, 1'b0,
          ~8'(1 << i), 1'b0);
    end
    run("R3 bit test zero", 8'h00, 8'hF7, 8'h60, 2'd3, 2'd1, 4'd1, 1'b0, 1'b1, 8'h00, 1'b1);
  endtask

  task automatic t_add;
    run("R4 add", 8'h12, 8'h34, 8'h00, 2'd0, 2'd1, 4'd0, 1'b0, 1'b1, 8'h46, 1'b0);
    run("R4 inc 7F", 8'h00, 8'h7F, 8'h00, 2'd1, 2'd3, 4'd0, 1'b0, 1'b0, 8'h80, 1'b0);
    run("R4 inc FF", 8'h00, 8'hFF, 8'h00, 2'd1, 2'd3, 4'd0, 1'b0, 1'b0, 8'h00, 1'b1);
  endtask

  task automatic t_sub;
    run("R5 f-w", 8'h03, 8'h05, 8'h00, 2'd1, 2'd0, 4'd8, 1'b0, 1'b0, 8'h02, 1'b1);
    run("R5 borrow", 8'h05, 8'h03, 8'h00, 2'd1, 2'd0, 4'd8, 1'b0, 1'b1, 8'hFE, 1'b0);
    run("R5 dec 1", 8'h00, 8'h01, 8'h00, 2'd1, 2'd3, 4'd8, 1'b0, 1'b0, 8'h00, 1'b1);
    run("R5 dec 0", 8'h00, 8'h00, 8'h00, 2'd1, 2'd3, 4'd8, 1'b0, 1'b1, 8'hFF, 1'b0);
  endtask

  task automatic t_logic;
    run("R6 and", 8'hF0, 8'h3C, 8'h00, 2'd0, 2'd1, 4'd1, 1'b0, 1'b1, 8'h30, 1'b1);
    run("R6 or",  8'hF0, 8'h3C, 8'h00, 2'd0, 2'd1, 4'd2, 1'b0, 1'b0, 8'hFC, 1'b0);
    run("R6 xor", 8'hF0, 8'h3C, 8'h00, 2'd0, 2'd1, 4'd3, 1'b0, 1'b1, 8'hCC, 1'b1);
    run("R6 clear w", 8'h5A, 8'h00, 8'h00, 2'd0, 2'd0, 4'd3, 1'b0, 1'b0, 8'h00, 1'b0);
    run("R6 move f", 8'h00, 8'h81, 8'h00, 2'd1, 2'd1, 4'd2, 1'b0, 1'b1, 8'h81, 1'b1);
  endtask

  task automatic t_cpl_swap;
    run("R7 cpl c1", 8'h00, 8'h0F, 8'h00, 2'd1, 2'd0, 4'd4, 1'b0, 1'b1, 8'hF0, 1'b1);
    run("R7 swap c0", 8'h00, 8'hA5, 8'h00, 2'd1, 2'd0, 4'd7, 1'b0, 1'b0, 8'h5A, 1'b0);
    run("R7 swap c1", 8'h00, 8'h12, 8'h00, 2'd1, 2'd0, 4'd7, 1'b0, 1'b1, 8'h21, 1'b1);
  endtask

  task automatic t_rotate;
    run("R8 rrc 81 c0", 8'h00, 8'h81, 8'h00, 2'd1, 2'd0, 4'd5, 1'b0, 1'b0, 8'h40, 1'b1);
    run("R8 rrc 81 c1", 8'h00, 8'h81, 8'h00, 2'd1, 2'd0, 4'd5, 1'b0, 1'b1, 8'hC0, 1'b1);
    run("R8 rrc 02 c1", 8'h00, 8'h02, 8'h00, 2'd1, 2'd0, 4'd5, 1'b0, 1'b1, 8'h81, 1'b0);
    run("R8 rrc 01 c0", 8'h00, 8'h01, 8'h00, 2'd1, 2'd0, 4'd5, 1'b0, 1'b0, 8'h00, 1'b1);
    run("R9 rlc 81 c0", 8'h00, 8'h81, 8'h00, 2'd1, 2'd0, 4'd6, 1'b0, 1'b0, 8'h02, 1'b1);
    run("R9 rlc 40 c1", 8'h00, 8'h40, 8'h00, 2'd1, 2'd0, 4'd6, 1'b0, 1'b1, 8'h81, 1'b0);
    run("R9 rlc 80 c0", 8'h00, 8'h80, 8'h00, 2'd1, 2'd0, 4'd6, 1'b0, 1'b0, 8'h00, 1'b1);
  endtask

  task automatic t_unused;
    for (int op = 9; op < 16; op++) begin
      run("R10 unused c1", 8'hFF, 8'hFF, 8'hFF, 2'd0, 2'd1, 4'(op), 1'b0, 1'b1, 8'h00, 1'b1);
      run("R10 unused c0", 8'hFF, 8'hFF, 8'hFF, 2'd0, 2'd1, 4'(op), 1'b0, 1'b0, 8'h00, 1'b0);
    end
  endtask

  task automatic t_sweep;  // R11 zero flag and overall agreement with the model
    logic [9:0] e;
    for (int k = 0; k < 300; k++) begin
      logic [7:0] w, f, imm;
      logic [1:0] as, bs;
      logic [3:0] op;
      logic inv, cin;
      w = 8'($urandom); f = 8'($urandom); imm = 8'($urandom);
      as = 2'($urandom); bs = 2'($urandom); op = 4'($urandom % 10);
      inv = 1'($urandom); cin = 1'($urandom);
      if (k % 5 == 0) f = w;
      e = model(w, f, imm, as, bs, op, inv, cin);
      apply(w, f, imm, as, bs, op, inv, cin);
      chk("R11 sweep", e[9:2], e[1], e[0]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst = 1;
    wreg_i = 0; freg_i = 0; imm_i = 0; a_sel_i = 0; b_sel_i = 0;
    op_i = 0; mask_inv_i = 0; carry_i = 0;
    @(negedge clk);
    t_reset();
    t_sel_a();
    t_sel_b();
    t_mask();
    t_add();
    t_sub();
    t_logic();
    t_cpl_swap();
    t_rotate();
    t_unused();
    t_sweep();
    t_reset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule